// File: doc/BRIEF.md
# Circular Transaction History Log

This block keeps a rolling record of the packet headers that a node sends and receives, so that a host can look back at the most recent traffic. Each accepted header is stored together with a direction flag in a wrap-around buffer. When the buffer is full, the newest entry replaces the oldest one instead of stalling the capture paths. The host therefore always sees the latest N entries, where N is a size it programs.

The host reads the oldest retained entry at the head of the log. It pops entries one at a time and watches a live count of valid entries. A capture arbiter serialises receive and transmit headers that arrive in the same cycle. It has two states. `ARB_IDLE` accepts captures. `ARB_HOLD` spends one cycle writing a transmit header that was parked in a one-deep holding register. The transitions are `ARB_IDLE -> ARB_HOLD` when both paths offer a header in the same accepted cycle, and `ARB_HOLD -> ARB_IDLE` unconditionally on the next cycle.

Pointer updates are classified each cycle as one of four operations: `OP_NONE`, `OP_PUSH`, `OP_POP` or `OP_BOTH`. A flush overrides all of them. A flush comes from an explicit clear or from a change of the effective size. Logging pauses while an inhibit input marks a configuration-ROM or status access in progress.

Top module: `txn_history_log`

## Requirements
- R1: After reset the log is empty: `log_count` is 0 and `rd_valid` is 0.
- R2: A single accepted capture stores one entry. `rd_dir` is 0 for a receive header and 1 for a transmit header, and `log_count` rises by one on the clock edge that samples the capture.
- R3: The head (`rd_hdr`/`rd_dir`) always shows the oldest retained entry, and pops return entries in arrival order.
- R4: When receive and transmit both offer a header in an accepted cycle, the receive entry is written at that edge and the transmit entry at the next edge. Captures offered during that second cycle are dropped.
- R5: While `log_inhibit` is 1, newly offered captures are ignored. A transmit header already parked in the holding register is still written.
- R6: A capture into a full log keeps `log_count` at the size, discards the oldest entry and moves the head to the next oldest.
- R7: `rd_en` with a non-empty log removes the head entry. `rd_en` on an empty log has no effect.
- R8: A capture and a pop in the same cycle leave `log_count` unchanged when the log is non-empty. On an empty log the pop is ignored and the count becomes 1.
- R9: `clr` empties the log in one cycle. It drops captures offered in that cycle and discards any parked transmit header.
- R10: The effective size is `cfg_size` when it lies in 1..DEPTH_MAX and DEPTH_MAX otherwise (0 included). A change of the effective size empties the log, and a write of a value with the same effective size does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive header offered this cycle |
| rx_hdr | input | DATA_W | Received packet header |
| tx_valid | input | 1 | Transmit header offered this cycle |
| tx_hdr | input | DATA_W | Transmitted packet header |
| log_inhibit | input | 1 | Pause capture (configuration-ROM/status access) |
| cfg_size | input | CNT_W | Programmed log size in entries |
| clr | input | 1 | Empty the log |
| rd_en | input | 1 | Pop the head entry |
| rd_valid | output | 1 | Log holds at least one entry |
| rd_dir | output | 1 | Direction of head entry (0 receive, 1 transmit) |
| rd_hdr | output | DATA_W | Header of head entry |
| log_count | output | CNT_W | Number of valid entries |

## Verification
A corrupted read or write pointer shows up as a wrong `rd_hdr` or `rd_dir` on the next observed head. This happens at the latest one edge after the pop or overwrite that exposes it. A count that drifts from the true occupancy appears directly on `log_count` and `rd_valid` in the cycle after the faulty update. Overwrite, wrap and flush errors are caught within a handful of cycles by popping the log empty and comparing every head against the expected arrival order. A holding register that is lost or written twice leaves a missing or duplicated transmit entry, which is visible as soon as the log is drained.

// File: rtl/txlog_pkg.sv
package txlog_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BOTH = 2'd3
    } ptr_op_e;

    localparam logic DIR_RX = 1'b0;
    localparam logic DIR_TX = 1'b1;

endpackage

// File: rtl/txlog_arbiter.sv
module txlog_arbiter
    import txlog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              inhibit,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_hdr,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_hdr,
    output logic              wr_req,
    output logic              wr_dir,
    output logic [DATA_W-1:0] wr_hdr
);

    arb_state_e        state_q, state_d;
    logic [DATA_W-1:0] held_q, held_d;

    // State register and holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        wr_req  = 1'b0;
        wr_dir  = DIR_RX;
        wr_hdr  = rx_hdr;
        unique case (state_q)
            ARB_IDLE: begin
                if (!flush && !inhibit) begin
                    if (rx_valid) begin
                        wr_req = 1'b1;
                        wr_dir = DIR_RX;
                        wr_hdr = rx_hdr;
                        if (tx_valid) begin
                            held_d  = tx_hdr;
                            state_d = ARB_HOLD;
                        end
                    end else if (tx_valid) begin
                        wr_req = 1'b1;
                        wr_dir = DIR_TX;
                        wr_hdr = tx_hdr;
                    end
                end
            end
            ARB_HOLD: begin
                state_d = ARB_IDLE;
                if (!flush) begin
                    wr_req = 1'b1;
                    wr_dir = DIR_TX;
                    wr_hdr = held_q;
                end
            end
        endcase
    end

    assert_hold_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ARB_HOLD |=> state_q == ARB_IDLE);

    assert_hold_writes_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HOLD && !flush) |-> (wr_req && wr_dir == DIR_TX));

    assert_inhibit_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && inhibit) |-> !wr_req);

    assert_flush_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !wr_req);

endmodule

// File: rtl/txlog_ptrs.sv
module txlog_ptrs
    import txlog_pkg::*;
#(
    parameter int DEPTH_MAX = 16,
    parameter int PTR_W     = 4,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] cfg_size,
    input  logic             wr_req,
    input  logic             rd_en,
    output logic             flush,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] MAX_SZ = CNT_W'(DEPTH_MAX);

    logic [CNT_W-1:0] eff_size, size_q;
    logic [PTR_W-1:0] wr_d, rd_d;
    logic [CNT_W-1:0] cnt_d;
    logic             pop_ok;
    ptr_op_e          op;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] lim);
        logic [CNT_W-1:0] n;
        n = CNT_W'(p) + CNT_W'(1);
        return (n >= lim) ? '0 : n[PTR_W-1:0];
    endfunction

    always_comb begin
        if (cfg_size == '0 || cfg_size > MAX_SZ) eff_size = MAX_SZ;
        else                                     eff_size = cfg_size;
    end

    assign flush  = clr || (eff_size != size_q);
    assign pop_ok = rd_en && (count != '0);

    always_comb begin
        unique case ({wr_req, pop_ok})
            2'b00: op = OP_NONE;
            2'b10: op = OP_PUSH;
            2'b01: op = OP_POP;
            2'b11: op = OP_BOTH;
        endcase
    end

    always_comb begin
        wr_d  = wr_ptr;
        rd_d  = rd_ptr;
        cnt_d = count;
        unique case (op)
            OP_NONE: ;
            OP_PUSH: begin
                wr_d = next_ptr(wr_ptr, size_q);
                if (count == size_q) rd_d  = next_ptr(rd_ptr, size_q);
                else                 cnt_d = count + CNT_W'(1);
            end
            OP_POP: begin
                rd_d  = next_ptr(rd_ptr, size_q);
                cnt_d = count - CNT_W'(1);
            end
            OP_BOTH: begin
                wr_d = next_ptr(wr_ptr, size_q);
                rd_d = next_ptr(rd_ptr, size_q);
            end
        endcase
        if (flush) begin
            wr_d  = '0;
            rd_d  = '0;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= MAX_SZ;
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            size_q <= eff_size;
            wr_ptr <= wr_d;
            rd_ptr <= rd_d;
            count  <= cnt_d;
        end
    end

    assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= size_q);

    assert_full_push_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wr_req && !rd_en && count == size_q) |=> count == $past(count));

    assert_empty_pop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !wr_req && rd_en && count == '0) |=> count == '0);

    assert_push_pop_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wr_req && rd_en && count != '0) |=> count == $past(count));

    assert_rd_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(rd_ptr) < size_q && CNT_W'(wr_ptr) < size_q);

endmodule

// File: rtl/txlog_store.sv
module txlog_store #(
    parameter int DATA_W    = 32,
    parameter int DEPTH_MAX = 16,
    parameter int PTR_W     = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic              wdir,
    input  logic [DATA_W-1:0] whdr,
    input  logic [PTR_W-1:0]  raddr,
    output logic              rdir,
    output logic [DATA_W-1:0] rhdr
);

    localparam int ENT_W = DATA_W + 1;

    logic [ENT_W-1:0] rows [DEPTH_MAX];

    for (genvar g = 0; g < DEPTH_MAX; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (we && waddr == PTR_W'(g)) rows[g] <= {wdir, whdr};
        end
    end

    assign {rdir, rhdr} = rows[raddr];

endmodule

// File: rtl/txn_history_log.sv
module txn_history_log
    import txlog_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DEPTH_MAX = 16,
    localparam int PTR_W    = $clog2(DEPTH_MAX),
    localparam int CNT_W    = $clog2(DEPTH_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_hdr,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_hdr,
    input  logic              log_inhibit,
    input  logic [CNT_W-1:0]  cfg_size,
    input  logic              clr,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic              rd_dir,
    output logic [DATA_W-1:0] rd_hdr,
    output logic [CNT_W-1:0]  log_count
);

    logic              flush;
    logic              wr_req;
    logic              wr_dir;
    logic [DATA_W-1:0] wr_hdr;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    txlog_arbiter #(.DATA_W(DATA_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .inhibit  (log_inhibit),
        .rx_valid (rx_valid),
        .rx_hdr   (rx_hdr),
        .tx_valid (tx_valid),
        .tx_hdr   (tx_hdr),
        .wr_req   (wr_req),
        .wr_dir   (wr_dir),
        .wr_hdr   (wr_hdr)
    );

    txlog_ptrs #(.DEPTH_MAX(DEPTH_MAX), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .cfg_size (cfg_size),
        .wr_req   (wr_req),
        .rd_en    (rd_en),
        .flush    (flush),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (log_count)
    );

    txlog_store #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .we    (wr_req),
        .waddr (wr_ptr),
        .wdir  (wr_dir),
        .whdr  (wr_hdr),
        .raddr (rd_ptr),
        .rdir  (rd_dir),
        .rhdr  (rd_hdr)
    );

    assign rd_valid = (log_count != '0);

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rd_valid);

    assert_single_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wr_req && !rd_en && log_count == '0) |=> log_count == CNT_W'(1));

endmodule

// File: tb/sim_txn_history_log.sv
module sim_txn_history_log;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0, tx_valid = 1'b0;
    logic [DATA_W-1:0] rx_hdr = '0, tx_hdr = '0;
    logic              log_inhibit = 1'b0, clr = 1'b0, rd_en = 1'b0;
    logic [CNT_W-1:0]  cfg_size = 5'd4;
    logic              rd_valid, rd_dir;
    logic [DATA_W-1:0] rd_hdr;
    logic [CNT_W-1:0]  log_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    txn_history_log #(.DATA_W(DATA_W), .DEPTH_MAX(16)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_hdr(rx_hdr),
        .tx_valid(tx_valid), .tx_hdr(tx_hdr),
        .log_inhibit(log_inhibit), .cfg_size(cfg_size),
        .clr(clr), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_dir(rd_dir),
        .rd_hdr(rd_hdr), .log_count(log_count)
    );

    typedef struct packed {
        logic       rxv;
        logic [7:0] rxh;
        logic       txv;
        logic [7:0] txh;
        logic       inh;
        logic       rd;
        logic [4:0] cnt;
        logic [7:0] hdr;
        logic       dir;
    } vec_t;

    localparam int NV = 20;
    // size 4 throughout the table; head expected after each edge
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'hA1, 1'b0, 8'h00, 1'b0, 1'b0, 5'd1, 8'hA1, 1'b0}, // R2 rx
        '{1'b0, 8'h00, 1'b1, 8'hB1, 1'b0, 1'b0, 5'd2, 8'hA1, 1'b0}, // R2 tx, R3 head
        '{1'b1, 8'hA2, 1'b1, 8'hB2, 1'b0, 1'b0, 5'd3, 8'hA1, 1'b0}, // R4 both
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 5'd4, 8'hA1, 1'b0}, // R4 held tx
        '{1'b1, 8'hA3, 1'b0, 8'h00, 1'b0, 1'b0, 5'd4, 8'hB1, 1'b1}, // R6 overwrite
        '{1'b1, 8'hA4, 1'b0, 8'h00, 1'b1, 1'b0, 5'd4, 8'hB1, 1'b1}, // R5 inhibit
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd3, 8'hA2, 1'b0}, // R7 pop, R3
        '{1'b0, 8'h00, 1'b1, 8'hB3, 1'b0, 1'b1, 5'd3, 8'hB2, 1'b1}, // R8
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd2, 8'hA3, 1'b0}, // R3
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd1, 8'hB3, 1'b1}, // R3
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd0, 8'h00, 1'b0}, // R7
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd0, 8'h00, 1'b0}, // R7 empty pop
        '{1'b1, 8'hA5, 1'b1, 8'hB5, 1'b0, 1'b0, 5'd1, 8'hA5, 1'b0}, // R4
        '{1'b1, 8'hA6, 1'b0, 8'h00, 1'b0, 1'b0, 5'd2, 8'hA5, 1'b0}, // R4 drop A6
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd1, 8'hB5, 1'b1}, // R4
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd0, 8'h00, 1'b0}, // R4
        '{1'b1, 8'hA7, 1'b1, 8'hB7, 1'b0, 1'b0, 5'd1, 8'hA7, 1'b0}, // R5 setup
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 5'd2, 8'hA7, 1'b0}, // R5 held under inhibit
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd1, 8'hB7, 1'b1}, // R5
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 5'd0, 8'h00, 1'b0}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        rx_valid = 1'b0; tx_valid = 1'b0; rx_hdr = '0; tx_hdr = '0;
        log_inhibit = 1'b0; clr = 1'b0; rd_en = 1'b0;
    endtask

    task automatic expect_state(input string req, input int cnt, input logic [7:0] hdr, input logic dir);
        check({req, " count"}, 32'(log_count), 32'(cnt));
        check({req, " valid"}, 32'(rd_valid), 32'(cnt != 0));
        if (cnt != 0) begin
            check({req, " hdr"}, rd_hdr, {24'h0, hdr});
            check({req, " dir"}, 32'(rd_dir), 32'(dir));
        end
    endtask

    task automatic push_rx(input logic [7:0] h);
        rx_valid = 1'b1; rx_hdr = {24'h0, h};
        step();
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        #25;
        check("R1 count in reset", 32'(log_count), 32'd0);
        rst_n = 1'b1;
        step();
        step();
        expect_state("R1", 0, 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            rx_valid    = VEC[i].rxv;
            rx_hdr      = {24'h0, VEC[i].rxh};
            tx_valid    = VEC[i].txv;
            tx_hdr      = {24'h0, VEC[i].txh};
            log_inhibit = VEC[i].inh;
            rd_en       = VEC[i].rd;
            step();
            expect_state($sformatf("table row %0d", i), int'(VEC[i].cnt), VEC[i].hdr, VEC[i].dir);
        end
        idle_inputs();

        // R9 clear of a partly filled log
        push_rx(8'h11); push_rx(8'h12); push_rx(8'h13);
        expect_state("R9 pre-clear", 3, 8'h11, 1'b0);
        clr = 1'b1; rx_valid = 1'b1; rx_hdr = 32'h14;
        step(); idle_inputs();
        expect_state("R9 clear", 0, 8'h00, 1'b0);

        // R9 clear discards parked transmit header
        rx_valid = 1'b1; rx_hdr = 32'h21; tx_valid = 1'b1; tx_hdr = 32'h22;
        step(); idle_inputs();
        expect_state("R9 both", 1, 8'h21, 1'b0);
        clr = 1'b1;
        step(); idle_inputs();
        step();
        expect_state("R9 held dropped", 0, 8'h00, 1'b0);

        // R10 size change flushes, new size governs wrap
        push_rx(8'h31);
        expect_state("R10 pre", 1, 8'h31, 1'b0);
        cfg_size = 5'd2;
        step();
        expect_state("R10 size flush", 0, 8'h00, 1'b0);
        push_rx(8'h32); push_rx(8'h33); push_rx(8'h34);
        expect_state("R10 size 2 wrap", 2, 8'h33, 1'b0);

        // R10 size 1
        cfg_size = 5'd1;
        step();
        push_rx(8'h41); push_rx(8'h42);
        expect_state("R10 size 1", 1, 8'h42, 1'b0);

        // R10 size 0 means DEPTH_MAX; R6 overwrite at 16
        cfg_size = 5'd0;
        step();
        expect_state("R10 size 0 flush", 0, 8'h00, 1'b0);
        for (int i = 0; i < 17; i++) push_rx(8'h50 + 8'(i));
        expect_state("R6 full 16", 16, 8'h51, 1'b0);
        for (int i = 0; i < 15; i++) begin
            rd_en = 1'b1; step(); idle_inputs();
        end
        expect_state("R3 last of 16", 1, 8'h60, 1'b0);
        rd_en = 1'b1; step(); idle_inputs();
        expect_state("R7 drained", 0, 8'h00, 1'b0);

        // R8 capture and pop on an empty log
        rd_en = 1'b1; rx_valid = 1'b1; rx_hdr = 32'h71;
        step(); idle_inputs();
        expect_state("R8 empty push+pop", 1, 8'h71, 1'b0);

        // R10 oversize value maps to DEPTH_MAX: no change, no flush
        cfg_size = 5'd20;
        step();
        step();
        expect_state("R10 oversize no flush", 1, 8'h71, 1'b0);

        // R2 lone transmit header carries dir 1
        rd_en = 1'b1; step(); idle_inputs();
        tx_valid = 1'b1; tx_hdr = 32'h81;
        step(); idle_inputs();
        expect_state("R2 tx dir", 1, 8'h81, 1'b1);

        done = 1'b1;
        finish_run();
    end

endmodule